// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer and Output Port

This block is the digital half of a 16-bit successive-approximation converter. It watches an active-low chip-select and an active-low read/convert line. It treats the two as one level-sensitive start condition that holds while both are low, so either line may be the one that falls last. When the condition first appears, the block puts the front end into hold, drops its busy flag and runs a most-significant-bit-first binary search against a single comparator bit from the analog side. It presents each trial word to the DAC. When the search ends, it stores the result in two's complement form and then releases busy.

A new start condition that appears while busy is low aborts the search. The block returns to tracking and keeps the last stored result. The result is read over a 16-bit port made of two 8-bit lanes. The port is enabled only while chip-select is low and read/convert is high, and a byte-select input exchanges the two lanes. The last result stays readable for a set number of cycles into a new conversion. After that window the port reads zero until the new result is stored.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is high and after it is released, busy is 1, hold is 0, the DAC trial word is 0 and the stored result is 0x0000.
- R2: A conversion starts at the first rising clock edge that samples chip-select and read/convert both low, whichever of them fell last. From that edge on, busy is 0 and hold is 1.
- R3: A conversion that is not interrupted keeps busy low for exactly W+1 clock cycles (W = 16). During that time hold is 1, and it returns to 0 when busy rises.
- R4: In conversion cycle k (1..W), the DAC word holds the bits already decided in positions W-1 down to W-k+1, plus a 1 in position W-k. A trial bit is kept when the comparator input is 1, which means the input is at or above the trial level. Outside a conversion the DAC word is 0.
- R5: The comparator works on offset binary. The stored result is the search word with its most significant bit inverted, giving two's complement. An ideal input v therefore yields v, for example 0x7FFF, 0x0000, 0xFFFF and 0x8000.
- R6: The new result is stored one cycle before busy rises. In the last busy-low cycle, the port already shows the new result.
- R7: A start condition that appears while busy is low aborts the conversion. On the next cycle busy is 1 and hold is 0, and the stored result is unchanged. A start condition that is held low does not start another conversion until it has been removed and applied again.
- R8: During conversion cycles 1..PV (PV = 8), the port shows the previous result. From cycle PV+1 until the new result is stored, it reads 0x0000.
- R9: Both lane enables are 1 only while chip-select is 0 and read/convert is 1. In every other case both enables are 0 and all 16 data outputs read 0.
- R10: With byte-select 0, data bits 15..8 carry result bits 15..8 and data bits 7..0 carry result bits 7..0. With byte-select 1, the two lanes are exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rc_n | input | 1 | Low: convert; high: read |
| lane_sel | input | 1 | Lane exchange select |
| cmp_hi | input | 1 | Comparator: input at or above trial level |
| busy | output | 1 | High when idle or tracking, low while a conversion runs |
| hold | output | 1 | Sample/hold control, 1 = hold |
| dac_word | output | 16 | Offset-binary trial word for the DAC |
| bus_out | output | 16 | Parallel data, two 8-bit lanes |
| lane_oe | output | 2 | Per-lane output enable, bit 1 upper lane |

## Verification
On every cycle, the assertions check four things. Busy falls only after the combined start condition was present. An abort restores busy on the next cycle. The DAC word stays idle outside a conversion. The port stays quiet whenever it is not selected for reading. The cycle-exact shape of the binary search, the length of the busy window, the previous-result window, the correct codes at the ends of the range and the lane exchange can only be shown by the bench scenarios. Those scenarios drive the comparator from an ideal input and compare each result against a queue of expected codes.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int unsigned DEF_WIDTH    = 16;
    localparam int unsigned DEF_PREV_CYC = 8;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LATCH  = 2'd2
    } sar_state_e;

    typedef struct packed {
        logic busy;
        logic hold;
    } seq_flags_t;

    typedef struct packed {
        logic drive;
        logic swap;
    } lane_ctl_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned W        = DEF_WIDTH,
    parameter int unsigned PREV_CYC = DEF_PREV_CYC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_lvl,
    input  logic         cmp_hi,
    output seq_flags_t   flags,
    output logic [W-1:0] dac_word,
    output logic [W-1:0] rd_word
);
    localparam int unsigned IW = $clog2(W);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] PV_LIM = CW'(PREV_CYC);
    localparam logic [W-1:0]  ONE    = {{(W-1){1'b0}}, 1'b1};

    sar_state_e     state;
    logic [IW-1:0]  idx;
    logic [W-1:0]   sar;
    logic [W-1:0]   result;
    logic [CW-1:0]  cnt;
    logic           start_q;

    logic           fire;
    logic [W-1:0]   trial_bit;
    logic [W-1:0]   kept;

    assign fire      = start_lvl & ~start_q;
    assign trial_bit = ONE << idx;
    assign kept      = cmp_hi ? (sar | trial_bit) : sar;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_TRACK;
            idx     <= '0;
            sar     <= '0;
            result  <= '0;
            cnt     <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_lvl;
            case (state)
                ST_TRACK: begin
                    if (fire) begin
                        state <= ST_SEARCH;
                        idx   <= IW'(W - 1);
                        sar   <= '0;
                        cnt   <= '0;
                    end
                end
                ST_SEARCH: begin
                    if (fire) begin
                        state <= ST_TRACK;
                        sar   <= '0;
                    end else begin
                        sar <= kept;
                        cnt <= cnt + 1'b1;
                        if (idx == '0) begin
                            result <= {~kept[W-1], kept[W-2:0]};
                            state  <= ST_LATCH;
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                default: state <= ST_TRACK;
            endcase
        end
    end

    assign flags.busy = (state == ST_TRACK);
    assign flags.hold = (state != ST_TRACK);
    assign dac_word   = (state == ST_SEARCH) ? (sar | trial_bit) : '0;
    assign rd_word    = (state == ST_SEARCH && cnt >= PV_LIM) ? '0 : result;

    // R2: busy only falls after the combined start condition was seen
    assert_start_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.busy) |-> $past(start_lvl));

    // R7: a fresh command during a conversion returns to tracking
    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (!flags.busy && fire) |=> flags.busy);

    // R4: no trial word is presented outside a conversion
    assert_idle_dac_R4: assert property (@(posedge clk) disable iff (rst)
        flags.busy |-> (dac_word == '0));

    // R6: the result is already stable when busy rises after a full search
    assert_load_early_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags.busy) && $past(state == ST_LATCH)) |-> $stable(result));

    // R3: the search never runs past W cycles
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        !flags.busy |-> (cnt <= CW'(W)));

endmodule

// File: rtl/sar_lanes.sv
module sar_lanes
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] word,
    output logic [W-1:0] bus_out,
    output logic [1:0]   lane_oe
);
    localparam int unsigned L = W / 2;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [L-1:0] src;
        assign src = ctl.swap ? word[(1-g)*L +: L] : word[g*L +: L];
        assign bus_out[g*L +: L] = ctl.drive ? src : '0;
        assign lane_oe[g]        = ctl.drive;
    end

    // R9: a deselected port stays quiet
    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !ctl.drive |-> (lane_oe == 2'b00 && bus_out == '0));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned W        = DEF_WIDTH,
    parameter int unsigned PREV_CYC = DEF_PREV_CYC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         rc_n,
    input  logic         lane_sel,
    input  logic         cmp_hi,
    output logic         busy,
    output logic         hold,
    output logic [W-1:0] dac_word,
    output logic [W-1:0] bus_out,
    output logic [1:0]   lane_oe
);
    seq_flags_t   flags;
    lane_ctl_t    ctl;
    logic [W-1:0] rd_word;
    logic         start_lvl;

    // combined control is active while the OR of both lines is low
    assign start_lvl = ~(cs_n | rc_n);
    assign ctl.drive = ~cs_n & rc_n;
    assign ctl.swap  = lane_sel;

    sar_seq #(.W(W), .PREV_CYC(PREV_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_lvl (start_lvl),
        .cmp_hi    (cmp_hi),
        .flags     (flags),
        .dac_word  (dac_word),
        .rd_word   (rd_word)
    );

    sar_lanes #(.W(W)) u_lanes (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .word    (rd_word),
        .bus_out (bus_out),
        .lane_oe (lane_oe)
    );

    assign busy = flags.busy;
    assign hold = flags.hold;

endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/100ps
module sar_adc_ctrl_tb;
    localparam int BW = 16;
    localparam int PV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, rc_n = 1'b1, lane_sel = 1'b0;
    logic cmp_hi;
    logic busy, hold;
    logic [BW-1:0] dac_word, bus_out;
    logic [1:0] lane_oe;

    logic [BW-1:0] vin = '0;
    logic [BW-1:0] off_in;
    logic [BW-1:0] prev_res = '0;
    logic [BW-1:0] exp_q[$];
    int total = 0, bad = 0;
    logic busy_d = 1'b1;

    always #2.5 clk = ~clk;

    // ideal comparator on offset binary
    assign off_in = {~vin[BW-1], vin[BW-2:0]};
    assign cmp_hi = (off_in >= dac_word);

    sar_adc_ctrl #(.W(BW), .PREV_CYC(PV)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .lane_sel(lane_sel),
        .cmp_hi(cmp_hi), .busy(busy), .hold(hold), .dac_word(dac_word),
        .bus_out(bus_out), .lane_oe(lane_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: pops expected codes when busy rises
    always @(negedge clk) begin
        #1;
        if (!rst && busy && !busy_d && exp_q.size() > 0) begin
            logic [BW-1:0] e;
            e = exp_q.pop_front();
            chk(bus_out == e, "R5 result code", bus_out, e);
        end
        busy_d = busy;
    end

    task automatic run_conv(input logic [BW-1:0] v, input bit via_cs);
        vin = v;
        if (via_cs) begin
            @(negedge clk); rc_n = 1'b0; cs_n = 1'b1;
            @(negedge clk); cs_n = 1'b0;
        end else begin
            @(negedge clk); rc_n = 1'b0;
        end
        @(negedge clk); rc_n = 1'b1; #1;
        chk(busy == 1'b0 && hold == 1'b1, "R2 start", {14'd0, busy, hold}, 16'h0001);
        exp_q.push_back(v);
        for (int k = 1; k <= BW; k++) begin
            int idx;
            logic [BW-1:0] ed, eb;
            idx = BW - k;
            ed = ((off_in >> (idx + 1)) << (idx + 1)) | (16'd1 << idx);
            if (idx == BW - 1) ed = 16'h8000;
            chk(dac_word == ed, "R4 trial word", dac_word, ed);
            eb = (k <= PV) ? prev_res : 16'h0000;
            chk(bus_out == eb, "R8 bus window", bus_out, eb);
            chk(busy == 1'b0, "R3 busy low", {15'd0, busy}, 16'd0);
            @(negedge clk); #1;
        end
        chk(busy == 1'b0, "R3 last low cycle", {15'd0, busy}, 16'd0);
        chk(bus_out == v, "R6 early load", bus_out, v);
        @(negedge clk); #1;
        chk(busy == 1'b1 && hold == 1'b0, "R3 release", {14'd0, busy, hold}, 16'h0002);
        chk(dac_word == 16'h0, "R4 idle dac", dac_word, 16'h0);
        prev_res = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b1 && hold == 1'b0, "R1 reset flags", {14'd0, busy, hold}, 16'h0002);
        @(negedge clk); rst = 1'b0; #1;
        chk(dac_word == 16'h0, "R1 reset dac", dac_word, 16'h0);
        chk(bus_out == 16'h0, "R1 reset result", bus_out, 16'h0);

        run_conv(16'h1234, 1'b0);
        run_conv(16'h7FFF, 1'b1);   // R2 chip-select falls last
        run_conv(16'h0000, 1'b0);
        run_conv(16'hFFFF, 1'b1);
        run_conv(16'h8000, 1'b0);
        run_conv(16'h5A3C, 1'b0);

        // R7 abort
        vin = 16'h4321;
        @(negedge clk); rc_n = 1'b0;
        @(negedge clk); rc_n = 1'b1;
        repeat (5) @(negedge clk);
        rc_n = 1'b0;
        @(negedge clk); #1;
        chk(busy == 1'b1 && hold == 1'b0, "R7 abort", {14'd0, busy, hold}, 16'h0002);
        repeat (3) begin
            @(negedge clk); #1;
            chk(busy == 1'b1, "R7 held no restart", {15'd0, busy}, 16'd1);
        end
        rc_n = 1'b1; #1;
        chk(bus_out == prev_res, "R7 result kept", bus_out, prev_res);

        // R9 port gating
        @(negedge clk); cs_n = 1'b1; #1;
        chk(lane_oe == 2'b00 && bus_out == 16'h0, "R9 cs high", bus_out, 16'h0);
        @(negedge clk); rc_n = 1'b0; #1;
        chk(lane_oe == 2'b00 && bus_out == 16'h0, "R9 cs high rc low", bus_out, 16'h0);
        @(negedge clk); rc_n = 1'b1; cs_n = 1'b0; #1;
        chk(lane_oe == 2'b11 && bus_out == prev_res, "R9 enabled", bus_out, prev_res);

        // R10 lane exchange
        @(negedge clk); lane_sel = 1'b1; #1;
        chk(bus_out == {prev_res[7:0], prev_res[15:8]}, "R10 swapped", bus_out,
            {prev_res[7:0], prev_res[15:8]});
        @(negedge clk); lane_sel = 1'b0; #1;
        chk(bus_out == prev_res, "R10 straight", bus_out, prev_res);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule